// File: doc/BRIEF.md
# Differential Dual-Channel Frequency Digitizer

This block turns two pulse-rate signals into one signed number per conversion window. One input carries a measurement pulse train. The other carries a free-running reference pulse train. A synchronous strobe marks the end of each window. Between strobes the block counts rising edges on each channel. When the strobe arrives it outputs the magnitude of the count difference, multiplied by a constant, together with a sign flag. It then restarts both counts from zero.

Any drift that shifts both pulse rates by the same amount appears in both counts, so it cancels in the difference. The pulse inputs may be asynchronous to the system clock. Because the two trains have no fixed phase relation, a window can lose or gain one count on either channel.

The result is held on the output bus until the next strobe. A one-cycle valid pulse marks each new result.

Top module: `dual_freq_digitizer`

## Requirements
- R1: Each rising edge on the measurement input (low for at least two clock cycles, then high for at least two) adds exactly one to the measurement count of the current window.
- R2: Each rising edge on the reference input, under the same timing conditions, adds exactly one to the reference count of the current window.
- R3: The output magnitude equals |Nmeas − Nref| × SCALE, clamped to 2^OUT_W − 1. It is zero when the counts are equal.
- R4: The sign flag is 1 exactly when Nref > Nmeas, and 0 when the counts are equal or Nmeas is larger.
- R5: A result appears one clock cycle after the clock edge that samples the sync strobe high. `valid_o` is high for that one cycle only. Magnitude, sign and overflow then hold until the next sync.
- R6: Each sync starts a new window, and both counts restart from zero.
- R7: An edge whose detection coincides with the sync cycle is counted in the new window, not in the one being closed.
- R8: Each count saturates at 2^CNT_W − 1 instead of wrapping. `ovf_o` is 1 with a result if either count in that window tried to go past the maximum.
- R9: After reset, magnitude, sign, overflow and valid are all 0.
- R10: A pulse input held high for many cycles counts once. Only rising transitions add to a count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| meas_pulse_i | input | 1 | Measurement pulse train, asynchronous |
| ref_pulse_i | input | 1 | Reference pulse train, asynchronous |
| sync_i | input | 1 | One-cycle strobe, synchronous to clk, that closes the window |
| mag_o | output | OUT_W | Scaled magnitude of the count difference |
| neg_o | output | 1 | Sign flag: 1 when the reference count is larger |
| ovf_o | output | 1 | A count saturated in the reported window |
| valid_o | output | 1 | One-cycle pulse marking a new result |

## Verification
The bench sweeps every pair of pulse counts from zero to beyond the counter limit, in a reduced configuration whose scaled difference can exceed the output width. This exercises these faults:
- A design that wraps its counters would report a small difference with the overflow flag clear.
- A design that skips the output clamp would return a truncated magnitude.
- Equal counts catch a sign flag that is raised on a tie.

An edge is placed so that its detection lands exactly on the sync cycle. A design that credits it to the closing window would report a nonzero result one window early.

A pulse held high for many cycles catches level counting instead of edge counting.

Between strobes the outputs are compared again, which catches a result that is not held.

// File: rtl/dfd_pkg.sv
package dfd_pkg;

    // number of metastability stages on each asynchronous pulse input
    localparam int unsigned SYNC_STAGES = 2;

    // two channels: index 0 measures, index 1 is the reference
    localparam int unsigned NUM_CH  = 2;
    localparam int unsigned CH_MEAS = 0;
    localparam int unsigned CH_REF  = 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] stage;
        logic                   prev;
    } edge_st_t;

endpackage

// File: rtl/dfd_edge_det.sv
module dfd_edge_det
    import dfd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_i,
    output logic rise_o
);

    edge_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.stage = {st_q.stage[SYNC_STAGES-2:0], pulse_i};
        st_d.prev  = st_q.stage[SYNC_STAGES-1];
        rise_o     = st_q.stage[SYNC_STAGES-1] & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R10: a detected rise can never last two cycles
    a_r10_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/dfd_win_counter.sv
module dfd_win_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            // the edge seen in the closing cycle belongs to the new window
            st_d.cnt = {{(CNT_W-1){1'b0}}, inc_i};
            st_d.ovf = 1'b0;
        end else if (inc_i) begin
            if (st_q.cnt == CNT_MAX) begin
                st_d.ovf = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        cnt_o = st_q.cnt;
        ovf_o = st_q.ovf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8: a full counter stays full until the window closes
    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == CNT_MAX && !clr_i) |=> cnt_o == CNT_MAX);

    // R1: within a window the count only holds or grows by one
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 1'b1));

    // R6: after a window closes the count is at most one
    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> cnt_o <= 1);

endmodule

// File: rtl/dfd_diff_scale.sv
module dfd_diff_scale #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned OUT_W = 18,
    parameter int unsigned SCALE = 1
) (
    input  logic [CNT_W-1:0] meas_i,
    input  logic [CNT_W-1:0] ref_i,
    output logic [OUT_W-1:0] mag_o,
    output logic             neg_o
);

    localparam int unsigned SW = $clog2(SCALE + 1);
    localparam int unsigned PW = CNT_W + SW;

    logic [CNT_W-1:0] diff;
    logic [PW-1:0]    prod;

    always_comb begin
        neg_o = ref_i > meas_i;
        diff  = neg_o ? (ref_i - meas_i) : (meas_i - ref_i);
        prod  = PW'(diff) * PW'(SCALE);
    end

    generate
        if (PW > OUT_W) begin : g_clamp
            always_comb begin
                mag_o = (|prod[PW-1:OUT_W]) ? {OUT_W{1'b1}} : prod[OUT_W-1:0];
            end
        end else begin : g_fit
            always_comb begin
                mag_o = OUT_W'(prod);
            end
        end
    endgenerate

    // R3: equal counts give a zero magnitude and a clear sign
    always_comb begin
        if (meas_i == ref_i) begin
            a_r3_equal_zero: assert (mag_o == '0 && !neg_o);
        end
    end

endmodule

// File: rtl/dual_freq_digitizer.sv
module dual_freq_digitizer
    import dfd_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned OUT_W = 18,
    parameter int unsigned SCALE = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             meas_pulse_i,
    input  logic             ref_pulse_i,
    input  logic             sync_i,
    output logic [OUT_W-1:0] mag_o,
    output logic             neg_o,
    output logic             ovf_o,
    output logic             valid_o
);

    typedef struct packed {
        logic [OUT_W-1:0] mag;
        logic             neg;
        logic             ovf;
        logic             vld;
    } res_st_t;

    logic [NUM_CH-1:0]            pulse_in;
    logic [NUM_CH-1:0]            rise;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt;
    logic [NUM_CH-1:0]            ch_ovf;
    logic [OUT_W-1:0]             diff_mag;
    logic                         diff_neg;

    assign pulse_in[CH_MEAS] = meas_pulse_i;
    assign pulse_in[CH_REF]  = ref_pulse_i;

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
            dfd_edge_det u_edge (
                .clk     (clk),
                .rst_n   (rst_n),
                .pulse_i (pulse_in[ch]),
                .rise_o  (rise[ch])
            );

            dfd_win_counter #(
                .CNT_W (CNT_W)
            ) u_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .inc_i (rise[ch]),
                .clr_i (sync_i),
                .cnt_o (cnt[ch]),
                .ovf_o (ch_ovf[ch])
            );
        end
    endgenerate

    dfd_diff_scale #(
        .CNT_W (CNT_W),
        .OUT_W (OUT_W),
        .SCALE (SCALE)
    ) u_diff (
        .meas_i (cnt[CH_MEAS]),
        .ref_i  (cnt[CH_REF]),
        .mag_o  (diff_mag),
        .neg_o  (diff_neg)
    );

    res_st_t res_d, res_q;

    always_comb begin
        res_d     = res_q;
        res_d.vld = 1'b0;
        if (sync_i) begin
            res_d.mag = diff_mag;
            res_d.neg = diff_neg;
            res_d.ovf = |ch_ovf;
            res_d.vld = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign mag_o   = res_q.mag;
    assign neg_o   = res_q.neg;
    assign ovf_o   = res_q.ovf;
    assign valid_o = res_q.vld;

    // R5: with no strobe the held result does not move and no valid is raised
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_i |=> ($stable(mag_o) && $stable(neg_o) && $stable(ovf_o) && !valid_o));

    // R4: a negative result always carries a nonzero magnitude
    a_r4_sign_mag: assert property (@(posedge clk) disable iff (!rst_n)
        neg_o |-> mag_o != '0);

endmodule

// File: tb/dual_freq_digitizer_tb.sv
module dual_freq_digitizer_tb;

    localparam int unsigned CNT_W = 4;
    localparam int unsigned OUT_W = 5;
    localparam int unsigned SCALE = 3;
    localparam int CMAX = (1 << CNT_W) - 1;
    localparam int OMAX = (1 << OUT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             meas = 1'b0;
    logic             refp = 1'b0;
    logic             sync = 1'b0;
    logic [OUT_W-1:0] mag;
    logic             neg;
    logic             ovf;
    logic             vld;

    int checks = 0;
    int fails  = 0;
    int exp_mag = 0;
    int exp_neg = 0;
    int exp_ovf = 0;

    always #4 clk = ~clk;

    dual_freq_digitizer #(
        .CNT_W (CNT_W),
        .OUT_W (OUT_W),
        .SCALE (SCALE)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .meas_pulse_i (meas),
        .ref_pulse_i  (refp),
        .sync_i       (sync),
        .mag_o        (mag),
        .neg_o        (neg),
        .ovf_o        (ovf),
        .valid_o      (vld)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // closes the window and checks the result against the expected values
    task automatic close_and_check(input string tag);
        sync = 1'b1;
        step(1);
        sync = 1'b0;
        chk({tag, " R5 valid"}, int'(vld), 1);
        chk({tag, " R3 mag"}, int'(mag), exp_mag);
        chk({tag, " R4 sign"}, int'(neg), exp_neg);
        chk({tag, " R8 ovf"}, int'(ovf), exp_ovf);
        step(1);
        chk({tag, " R5 valid one cycle"}, int'(vld), 0);
    endtask

    task automatic set_expect(input int n1, input int n2);
        int c1;
        int c2;
        int d;
        c1 = (n1 > CMAX) ? CMAX : n1;
        c2 = (n2 > CMAX) ? CMAX : n2;
        d  = (c1 > c2) ? (c1 - c2) : (c2 - c1);
        exp_mag = (d * SCALE > OMAX) ? OMAX : d * SCALE;
        exp_neg = (c2 > c1) ? 1 : 0;
        exp_ovf = (n1 > CMAX || n2 > CMAX) ? 1 : 0;
    endtask

    // R1 R2 R6: a window with n1 measurement and n2 reference pulses
    task automatic run_window(input int n1, input int n2);
        int top;
        top = (n1 > n2) ? n1 : n2;
        for (int i = 0; i < top; i++) begin
            meas = (i < n1);
            refp = (i < n2);
            step(2);
            meas = 1'b0;
            refp = 1'b0;
            step(2);
        end
        step(4);
        // R5: the previous result is still held before the strobe
        chk("R5 hold mag", int'(mag), exp_mag);
        chk("R5 hold sign", int'(neg), exp_neg);
        set_expect(n1, n2);
        close_and_check("R1 R2 R6");
    endtask

    initial begin
        step(3);
        chk("R9 reset mag", int'(mag), 0);
        chk("R9 reset sign", int'(neg), 0);
        chk("R9 reset ovf", int'(ovf), 0);
        chk("R9 reset valid", int'(vld), 0);
        rst_n = 1'b1;
        step(2);

        // near-exhaustive sweep, past the counter limit on both channels
        for (int a = 0; a <= CMAX + 2; a++) begin
            for (int b = 0; b <= CMAX + 2; b++) begin
                run_window(a, b);
            end
        end

        // R10: a long high level counts as one edge
        meas = 1'b1;
        step(20);
        meas = 1'b0;
        step(6);
        set_expect(1, 0);
        close_and_check("R10 level");

        // R7: edge detected in the very cycle of the strobe
        meas = 1'b1;
        step(2);
        sync = 1'b1;
        step(1);
        sync = 1'b0;
        meas = 1'b0;
        chk("R7 closing window excludes edge", int'(mag), 0);
        chk("R7 valid", int'(vld), 1);
        step(6);
        set_expect(1, 0);
        close_and_check("R7 new window");

        // R6: an empty window after activity reports zero
        step(5);
        set_expect(0, 0);
        close_and_check("R6 empty");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R5 watchdog: actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule